// File: doc/BRIEF.md
# Bipolar Stepper Bridge Controller

This block is the digital control for the two H-bridges of a two-phase bipolar stepper driver. Each channel has a direction input. The block turns it into switch enables for the two half-bridges of that channel, so current flows one way or the other through the winding. A power-save input chooses which supply feeds the high-side switches: the high-voltage rail for normal drive, or the low-voltage rail for holding torque at reduced current. An active-low standby input switches every output off.

Several protection paths sit around the decode. An overcurrent flag from any monitored switch has to stay up for a fixed qualification time. After that the block latches off. The latch is released only by an undervoltage flag, or by a standby pulse that is long enough; after such a pulse the outputs come back once a fixed re-arm delay has passed. Supply comparator flags force a lockout while they are set. A digital die-temperature code drives a thermal shutdown that has hysteresis. Three status bits report the overcurrent latch, the undervoltage lockout and the thermal fault separately.

Every half-bridge has three enables: high side from the high-voltage rail, high side from the low-voltage rail, and low side. When an output is off (high impedance), all three are low. Half-bridge index 0 is channel A phase, 1 is channel A inverted phase, 2 is channel B phase and 3 is channel B inverted phase.

Top module: `bbc_ctrl`

## Requirements
- R1: Direction for channel A is `dir_a`, for channel B `dir_b`. When the direction is high, the channel's phase half-bridge (index 0 or 2) drives its high side and the inverted half-bridge (1 or 3) drives its low side. When the direction is low, the two swap. All enables and status bits are registered and follow their inputs one clock edge later.
- R2: With `pwr_save` low, the high-side enables appear on `en_hi_hv`. With `pwr_save` high, they appear on `en_hi_lv`. Low-side enables on `en_lo` do not depend on `pwr_save`.
- R3: While `stby_n` is low, all enables are zero one edge later.
- R4: After reset, all enables and status bits are zero and the overcurrent latch is clear. Each half-bridge has at most one of its three enables set at any time.
- R5: Any set bit of `oc_lo` that stays set for MASK_US microseconds (MASK_CYC consecutive edges) sets `flt_oc` at edge MASK_CYC and forces all enables to zero from the next edge. `flt_oc` stays set after the flag drops. A flag that lasts fewer edges has no effect.
- R6: Bits of `oc_hi` are ignored while `pwr_save` is high and qualify like `oc_lo` while it is low. `oc_lo` is monitored in both modes.
- R7: Any set undervoltage flag (`uv_ctl`, `uv_lv`, `uv_hv_a`, `uv_hv_b`) clears the overcurrent latch at the next edge.
- R8: A rising `stby_n` after at least STBY_US microseconds low (STBY_CYC edges) clears the overcurrent latch at that edge. Enables stay zero for REARM_CYC edges counted from that edge and return at the edge after. A shorter low pulse leaves the latch unchanged.
- R9: Enables are zero and `flt_uv` is set while `uv_ctl` is high, or `uv_lv` is high, or both `uv_hv_a` and `uv_hv_b` are high. A single high-voltage flag on its own causes no lockout.
- R10: `flt_ot` sets when `temp_code` exceeds TEMP_TRIP and clears only when it falls to TEMP_REL or below. Enables are zero one edge after `flt_ot` is set.
- R11: `flt_oc`, `flt_uv` and `flt_ot` report their own conditions independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Channel A direction |
| dir_b | input | 1 | Channel B direction |
| pwr_save | input | 1 | 1 = high side from low-voltage rail |
| stby_n | input | 1 | 0 = standby, all outputs off |
| oc_hi | input | 4 | Overcurrent flag per half-bridge, high-side switch |
| oc_lo | input | 4 | Overcurrent flag per half-bridge, low-side switch |
| uv_ctl | input | 1 | Control supply undervoltage flag |
| uv_lv | input | 1 | Low-voltage rail undervoltage flag |
| uv_hv_a | input | 1 | High-voltage rail A undervoltage flag |
| uv_hv_b | input | 1 | High-voltage rail B undervoltage flag |
| temp_code | input | TEMP_W | Die temperature code |
| en_hi_hv | output | 4 | High-side enable from high-voltage rail, per half-bridge |
| en_hi_lv | output | 4 | High-side enable from low-voltage rail, per half-bridge |
| en_lo | output | 4 | Low-side enable, per half-bridge |
| flt_oc | output | 1 | Overcurrent latch set |
| flt_uv | output | 1 | Undervoltage lockout active |
| flt_ot | output | 1 | Thermal shutdown active |

## Verification
Direction, power-save, standby and undervoltage changes show up on the enables one edge after the edge that samples them. A temperature crossing moves `flt_ot` after one edge and the enables after two. A qualified overcurrent sets `flt_oc` at edge MASK_CYC and drops the enables one edge later. After a long standby pulse, the enables come back at edge REARM_CYC+1. The driver stamps each expected value with the exact cycle it is due. The monitor compares only at that cycle and samples on the falling clock edge, and it flags any item whose cycle has already passed.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned NUM_HB = 2 * NUM_CH;

    // drive state of one half-bridge
    typedef enum logic [1:0] {
        HB_OFF     = 2'd0,
        HB_HIGH_HV = 2'd1,
        HB_HIGH_LV = 2'd2,
        HB_LOW     = 2'd3
    } hb_state_e;

    function automatic int unsigned cyc_of_us(input int unsigned clk_hz, input int unsigned usec);
        return (clk_hz / 32'd1_000_000) * usec;
    endfunction

endpackage

// File: rtl/bbc_hb_map.sv
module bbc_hb_map
    import bbc_pkg::*;
(
    input  logic [NUM_CH-1:0] dir,
    input  logic              pwr_save,
    input  logic              drive_ok,
    output hb_state_e         hb_st [NUM_HB]
);

    hb_state_e hi_sel;

    always_comb begin
        hi_sel = pwr_save ? HB_HIGH_LV : HB_HIGH_HV;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            hb_st[2*c]   = HB_OFF;
            hb_st[2*c+1] = HB_OFF;
            if (drive_ok) begin
                hb_st[2*c]   = dir[c] ? hi_sel : HB_LOW;
                hb_st[2*c+1] = dir[c] ? HB_LOW : hi_sel;
            end
        end
    end

endmodule

// File: rtl/bbc_thermal.sv
module bbc_thermal #(
    parameter int unsigned TW   = 8,
    parameter int unsigned TRIP = 160,
    parameter int unsigned REL  = 140
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_code,
    output logic          ot
);

    logic ot_d, ot_q;

    always_comb begin
        if (ot_q) ot_d = (temp_code > TW'(REL));
        else      ot_d = (temp_code > TW'(TRIP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ot_q <= 1'b0;
        else        ot_q <= ot_d;
    end

    assign ot = ot_q;

    // once tripped, stays tripped until the code reaches the release level
    p_hold_above_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ot_q && (temp_code > TW'(REL)) |=> ot_q);
    // never trips at or below the trip level
    p_no_trip_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ot_q && (temp_code <= TW'(TRIP)) |=> !ot_q);

endmodule

// File: rtl/bbc_ocp_guard.sv
module bbc_ocp_guard #(
    parameter int unsigned NHB       = 4,
    parameter int unsigned MASK_CYC  = 2000,
    parameter int unsigned STBY_CYC  = 2000,
    parameter int unsigned REARM_CYC = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NHB-1:0] oc_hi,
    input  logic [NHB-1:0] oc_lo,
    input  logic           pwr_save,
    input  logic           stby_n,
    input  logic           uv_any,
    output logic           oc_latched,
    output logic           hold_off
);

    localparam int unsigned MW = $clog2(MASK_CYC + 1);
    localparam int unsigned SW = $clog2(STBY_CYC + 1);
    localparam int unsigned RW = $clog2(REARM_CYC + 1);

    typedef struct packed {
        logic [MW-1:0] mask_cnt;
        logic [SW-1:0] low_cnt;
        logic [RW-1:0] wait_cnt;
        logic          stby_prev;
        logic          latch;
    } ocp_st_t;

    ocp_st_t d, q;
    logic    oc_seen;
    logic    long_low;
    logic    stby_rise;
    logic    clear_ok;

    always_comb begin
        oc_seen   = (|oc_lo) | ((|oc_hi) & ~pwr_save);
        long_low  = (q.low_cnt == SW'(STBY_CYC));
        stby_rise = stby_n & ~q.stby_prev;
        clear_ok  = stby_rise & long_low;

        d           = q;
        d.stby_prev = stby_n;

        // standby low-time measurement, saturating
        if (stby_n)        d.low_cnt = '0;
        else if (!long_low) d.low_cnt = q.low_cnt + SW'(1);

        // re-arm countdown
        if (q.wait_cnt != '0) d.wait_cnt = q.wait_cnt - RW'(1);

        // overcurrent qualification
        if (!oc_seen) begin
            d.mask_cnt = '0;
        end else if (q.mask_cnt != MW'(MASK_CYC - 1)) begin
            d.mask_cnt = q.mask_cnt + MW'(1);
        end else begin
            d.latch = 1'b1;
        end

        // release paths override the set
        if (uv_any) begin
            d.latch    = 1'b0;
            d.mask_cnt = '0;
        end
        if (clear_ok) begin
            d.latch    = 1'b0;
            d.mask_cnt = '0;
            d.wait_cnt = RW'(REARM_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign oc_latched = q.latch;
    assign hold_off   = clear_ok | (q.wait_cnt != '0);

    p_latch_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.latch && !uv_any && !(stby_n && !q.stby_prev) |=> q.latch);
    p_uv_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_any |=> !q.latch);
    p_hs_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.latch && pwr_save && !(|oc_lo) |=> !q.latch);
    p_rearm_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.latch) && !$past(uv_any) |-> hold_off);

endmodule

// File: rtl/bbc_ctrl.sv
module bbc_ctrl
    import bbc_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned MASK_US   = 20,
    parameter int unsigned STBY_US   = 20,
    parameter int unsigned REARM_US  = 10,
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned TEMP_TRIP = 160,
    parameter int unsigned TEMP_REL  = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_a,
    input  logic              dir_b,
    input  logic              pwr_save,
    input  logic              stby_n,
    input  logic [3:0]        oc_hi,
    input  logic [3:0]        oc_lo,
    input  logic              uv_ctl,
    input  logic              uv_lv,
    input  logic              uv_hv_a,
    input  logic              uv_hv_b,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [3:0]        en_hi_hv,
    output logic [3:0]        en_hi_lv,
    output logic [3:0]        en_lo,
    output logic              flt_oc,
    output logic              flt_uv,
    output logic              flt_ot
);

    localparam int unsigned MASK_CYC  = cyc_of_us(CLK_HZ, MASK_US);
    localparam int unsigned STBY_CYC  = cyc_of_us(CLK_HZ, STBY_US);
    localparam int unsigned REARM_CYC = cyc_of_us(CLK_HZ, REARM_US);

    typedef struct packed {
        logic [NUM_HB-1:0] hv;
        logic [NUM_HB-1:0] lv;
        logic [NUM_HB-1:0] lo;
        logic              uv;
    } out_st_t;

    out_st_t           d, q;
    logic              uv_lock, uv_any;
    logic              oc_latched, hold_off, ot;
    logic              drive_ok;
    hb_state_e         hb_st [NUM_HB];
    logic [NUM_HB-1:0] hv_n, lv_n, lo_n;

    assign uv_lock  = uv_ctl | uv_lv | (uv_hv_a & uv_hv_b);
    assign uv_any   = uv_ctl | uv_lv | uv_hv_a | uv_hv_b;
    assign drive_ok = stby_n & ~uv_lock & ~oc_latched & ~hold_off & ~ot;

    bbc_ocp_guard #(
        .NHB      (NUM_HB),
        .MASK_CYC (MASK_CYC),
        .STBY_CYC (STBY_CYC),
        .REARM_CYC(REARM_CYC)
    ) u_ocp (
        .clk       (clk),
        .rst_n     (rst_n),
        .oc_hi     (oc_hi),
        .oc_lo     (oc_lo),
        .pwr_save  (pwr_save),
        .stby_n    (stby_n),
        .uv_any    (uv_any),
        .oc_latched(oc_latched),
        .hold_off  (hold_off)
    );

    bbc_thermal #(
        .TW  (TEMP_W),
        .TRIP(TEMP_TRIP),
        .REL (TEMP_REL)
    ) u_thermal (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_code(temp_code),
        .ot       (ot)
    );

    bbc_hb_map u_map (
        .dir     ({dir_b, dir_a}),
        .pwr_save(pwr_save),
        .drive_ok(drive_ok),
        .hb_st   (hb_st)
    );

    for (genvar h = 0; h < int'(NUM_HB); h++) begin : g_hb
        assign hv_n[h] = (hb_st[h] == HB_HIGH_HV);
        assign lv_n[h] = (hb_st[h] == HB_HIGH_LV);
        assign lo_n[h] = (hb_st[h] == HB_LOW);

        p_one_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({q.hv[h], q.lv[h], q.lo[h]}) <= 1);
    end

    always_comb begin
        d.hv = hv_n;
        d.lv = lv_n;
        d.lo = lo_n;
        d.uv = uv_lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_hi_hv = q.hv;
    assign en_hi_lv = q.lv;
    assign en_lo    = q.lo;
    assign flt_uv   = q.uv;
    assign flt_oc   = oc_latched;
    assign flt_ot   = ot;

    p_stby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |=> (en_hi_hv == '0 && en_hi_lv == '0 && en_lo == '0));
    p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_ctl || uv_lv || (uv_hv_a && uv_hv_b)) |=> (en_hi_hv == '0 && en_hi_lv == '0 && en_lo == '0));
    p_oc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_oc |=> (en_hi_hv == '0 && en_hi_lv == '0 && en_lo == '0));
    p_ot_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ot |=> (en_hi_hv == '0 && en_hi_lv == '0 && en_lo == '0));

endmodule

// File: tb/test_bbc_ctrl.sv
module test_bbc_ctrl;

    localparam int CYC_PER_US = 100;
    localparam int MASK  = 20 * CYC_PER_US;
    localparam int STBY  = 20 * CYC_PER_US;
    localparam int REARM = 10 * CYC_PER_US;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dir_a, dir_b, pwr_save, stby_n;
    logic [3:0] oc_hi, oc_lo;
    logic       uv_ctl, uv_lv, uv_hv_a, uv_hv_b;
    logic [7:0] temp_code;
    logic [3:0] en_hi_hv, en_hi_lv, en_lo;
    logic       flt_oc, flt_uv, flt_ot;

    int cyc    = 0;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int          at;
        logic [14:0] val;
        string       tag;
    } item_t;
    item_t sbq[$];
    item_t it;

    bbc_ctrl i_bbc_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
        .pwr_save(pwr_save), .stby_n(stby_n), .oc_hi(oc_hi), .oc_lo(oc_lo),
        .uv_ctl(uv_ctl), .uv_lv(uv_lv), .uv_hv_a(uv_hv_a), .uv_hv_b(uv_hv_b),
        .temp_code(temp_code), .en_hi_hv(en_hi_hv), .en_hi_lv(en_hi_lv),
        .en_lo(en_lo), .flt_oc(flt_oc), .flt_uv(flt_uv), .flt_ot(flt_ot)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [14:0] observed();
        return {en_hi_hv, en_hi_lv, en_lo, flt_oc, flt_uv, flt_ot};
    endfunction

    // enables expected from direction and power-save, plus status {oc,uv,ot}
    function automatic logic [14:0] on_val(input logic [2:0] st);
        logic [3:0] hi;
        hi = {~dir_b, dir_b, ~dir_a, dir_a};
        return pwr_save ? {4'b0, hi, ~hi, st} : {hi, 4'b0, ~hi, st};
    endfunction

    function automatic logic [14:0] off_val(input logic [2:0] st);
        return {12'b0, st};
    endfunction

    task automatic check(input logic [14:0] act, input logic [14:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic push(input int dly, input logic [14:0] v, input string tag);
        sbq.push_back('{cyc + dly, v, tag});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each item in the cycle it is due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            it = sbq.pop_front();
            if (it.at < cyc) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s: stale item, actual cycle %0d expected %0d", it.tag, cyc, it.at);
            end else begin
                check(observed(), it.val, it.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dir_a = 1'b0; dir_b = 1'b0; pwr_save = 1'b0; stby_n = 1'b1;
        oc_hi = '0; oc_lo = '0; uv_ctl = 1'b0; uv_lv = 1'b0; uv_hv_a = 1'b0; uv_hv_b = 1'b0;
        temp_code = 8'd25;
        step(3);
        check(observed(), 15'b0, "R4 reset state");
        rst_n = 1'b1;
        push(1, on_val(3'b000), "R1 first drive after reset");
        step(2);

        // direction and supply selection patterns
        for (int p = 0; p < 8; p++) begin
            dir_a = p[0]; dir_b = p[1]; pwr_save = p[2];
            push(1, on_val(3'b000), p[2] ? "R2 low-voltage high side" : "R1 direction map");
            step(2);
        end
        dir_a = 1'b1; dir_b = 1'b0; pwr_save = 1'b0;
        step(2);

        // short standby pulse
        stby_n = 1'b0;
        push(1, off_val(3'b000), "R3 standby off");
        step(5);
        stby_n = 1'b1;
        push(1, on_val(3'b000), "R8 short standby resumes at once");
        step(2);

        // undervoltage lockout combinations
        uv_ctl = 1'b1;
        push(1, off_val(3'b010), "R9 control supply lockout");
        step(2);
        uv_ctl = 1'b0;
        push(1, on_val(3'b000), "R9 control supply recovered");
        step(2);
        uv_hv_a = 1'b1;
        push(1, on_val(3'b000), "R9 single high-voltage flag no lockout");
        step(2);
        uv_hv_b = 1'b1;
        push(1, off_val(3'b010), "R9 both high-voltage flags lockout");
        step(2);
        uv_hv_a = 1'b0; uv_hv_b = 1'b0; uv_lv = 1'b1;
        push(1, off_val(3'b010), "R9 low-voltage supply lockout");
        step(2);
        uv_lv = 1'b0;
        push(1, on_val(3'b000), "R11 uv status clears alone");
        step(2);

        // overcurrent one cycle short of the mask
        oc_lo = 4'b0001;
        step(MASK - 1);
        oc_lo = 4'b0000;
        push(1, on_val(3'b000), "R5 short overcurrent ignored");
        push(3, on_val(3'b000), "R5 short overcurrent ignored later");
        step(4);

        // qualified overcurrent
        oc_lo = 4'b0010;
        push(MASK, on_val(3'b100), "R5 latch sets at mask end");
        push(MASK + 1, off_val(3'b100), "R5 outputs off after latch");
        step(MASK + 2);
        oc_lo = 4'b0000;
        push(2, off_val(3'b100), "R5 latch holds after flag drops");
        step(3);

        // undervoltage releases the latch
        uv_lv = 1'b1;
        push(1, off_val(3'b010), "R7 uv clears latch");
        step(1);
        uv_lv = 1'b0;
        push(1, on_val(3'b000), "R7 drive back after uv");
        step(2);

        // high-side flags in power-save mode
        pwr_save = 1'b1; oc_hi = 4'hF;
        step(MASK + 5);
        push(1, on_val(3'b000), "R6 high-side flags ignored in power save");
        step(2);
        oc_hi = 4'h0; pwr_save = 1'b0;
        push(1, on_val(3'b000), "R6 back to high-voltage drive");
        step(2);
        oc_hi = 4'b0100;
        step(MASK + 2);
        oc_hi = 4'h0;
        push(1, off_val(3'b100), "R6 high-side flag latches in normal mode");
        step(2);

        // standby one cycle too short keeps the latch
        stby_n = 1'b0;
        push(1, off_val(3'b100), "R3 standby while latched");
        step(STBY - 1);
        stby_n = 1'b1;
        push(1, off_val(3'b100), "R8 short pulse keeps latch");
        push(3, off_val(3'b100), "R8 short pulse keeps latch later");
        step(4);

        // long standby clears and re-arms
        stby_n = 1'b0;
        step(STBY);
        stby_n = 1'b1;
        push(1, off_val(3'b000), "R8 long pulse clears latch");
        push(REARM, off_val(3'b000), "R8 still held at end of re-arm");
        push(REARM + 1, on_val(3'b000), "R8 resume after re-arm");
        step(REARM + 3);

        // thermal hysteresis
        temp_code = 8'd160;
        push(2, on_val(3'b000), "R10 at trip level no shutdown");
        step(3);
        temp_code = 8'd161;
        push(1, on_val(3'b001), "R10 thermal flag sets");
        push(2, off_val(3'b001), "R10 outputs off on thermal");
        step(3);
        temp_code = 8'd141;
        push(2, off_val(3'b001), "R10 hysteresis holds above release");
        step(3);
        temp_code = 8'd140;
        push(1, off_val(3'b000), "R11 thermal status clears");
        push(2, on_val(3'b000), "R10 released at release level");
        step(3);

        while (sbq.size() > 0) step(1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule